// File: doc/BRIEF.md
# Flash Write Completion Poller

This engine sits on the host side of a parallel NOR flash and performs one write-type operation per request: a byte program, a sector erase or a whole-array erase. On a start pulse it emits the protected unlock command sequence as single-cycle writes on a simple synchronous bus master. Immediately after the last command write it begins reading back the target location and watching the device's status bits until the operation is over.

Two end-of-write detection methods are available, chosen per request. The first waits for bit 6 to stop alternating between consecutive reads. The second compares bit 7 against the value expected at completion. The flash finishes asynchronously to the host reads, so a read that straddles the finish can look complete when it is not. For that reason an apparent completion is accepted only after two further reads of the same location also qualify. Each operation kind has its own cycle-count timeout. When that budget runs out, the engine ends with an error indication instead of waiting forever.

Top module: `flash_poll_engine`

## Requirements
- R1: A start pulse is taken only while `busy` is low. `busy` is high from the next cycle until the cycle that carries `done`. A start seen while busy changes neither the bus traffic nor the number of `done` pulses.
- R2: With `op`=0 (byte program) the engine writes, in four consecutive cycles: (5555h, AAh), (2AAAh, 55h), (5555h, A0h), (`start_addr`, `start_data`).
- R3: With `op`=1 (sector erase) the engine writes, in six consecutive cycles: (5555h, AAh), (2AAAh, 55h), (5555h, 80h), (5555h, AAh), (2AAAh, 55h), (`start_addr`, 30h).
- R4: With `op`=2 or 3 (whole-array erase), the six writes match R3 except the last one, which is (5555h, 10h).
- R5: No read is issued before the clock edge that ends the final command write. Every status read targets `start_addr`. Each read strobe lasts one cycle and is followed by one idle bus cycle, and `bus_rdata` is sampled at the end of that idle cycle.
- R6: With `poll_mode`=0, a read qualifies when its bit 6 equals bit 6 of the previous read of the same operation. The first read never qualifies.
- R7: With `poll_mode`=1, a read qualifies when its bit 7 equals bit 7 of `start_data` for a program, or equals 1 for either erase.
- R8: The operation completes only on the third qualifying read in an unbroken run. A read that does not qualify restarts the count, so an apparent completion needs two more confirming reads.
- R9: On completion `done` is high for exactly one cycle with `err` low, and the engine returns to idle.
- R10: If completion has not happened, `done` and `err` rise together at the LIMIT-th clock edge after the edge that ends the final command write. LIMIT is `PROG_TMO`, `SECT_TMO` or `CHIP_TMO` according to the operation. The engine then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request pulse |
| op | input | 2 | 0 program, 1 sector erase, 2/3 whole-array erase |
| poll_mode | input | 1 | 0 bit-6 toggle detection, 1 bit-7 data detection |
| start_addr | input | AW | Target byte or sector address |
| start_data | input | 8 | Byte to program |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle end pulse |
| err | output | 1 | Timeout flag, valid with done |
| bus_wr | output | 1 | Bus write strobe |
| bus_rd | output | 1 | Bus read strobe |
| bus_addr | output | AW | Bus address |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data, valid the cycle after bus_rd |

## Verification
The bench models a device that stays busy for a chosen number of reads. It can inject a single spurious read that looks finished, either by repeating bit 6 or by returning true bit 7 early. An engine that skips the two confirmation reads finishes too soon, and one that does not restart the count after a failed read finishes at the wrong read. Both show up as a read count different from the one the bench derives from the logged read data. Further scenarios target other faults: a wrong final command byte or address for each operation kind, a timeout budget taken from the wrong operation or off by one edge, and a mid-operation start that triggers a second command stream.

// File: rtl/flash_poll_engine.sv
`timescale 1ns/1ps
module flash_poll_engine #(
  parameter int AW       = 19,
  parameter int PROG_TMO = 5000,
  parameter int SECT_TMO = 6250000,
  parameter int CHIP_TMO = 25000000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [1:0]    op,
  input  logic          poll_mode,
  input  logic [AW-1:0] start_addr,
  input  logic [7:0]    start_data,
  output logic          busy,
  output logic          done,
  output logic          err,
  output logic          bus_wr,
  output logic          bus_rd,
  output logic [AW-1:0] bus_addr,
  output logic [7:0]    bus_wdata,
  input  logic [7:0]    bus_rdata
);

  localparam int MAXT  = (PROG_TMO > SECT_TMO) ? ((PROG_TMO > CHIP_TMO) ? PROG_TMO : CHIP_TMO)
                                               : ((SECT_TMO > CHIP_TMO) ? SECT_TMO : CHIP_TMO);
  localparam int CW    = $clog2(MAXT + 1);
  localparam logic [AW-1:0] KEY_A = AW'(16'h5555);
  localparam logic [AW-1:0] KEY_B = AW'(16'h2AAA);

  typedef enum logic [1:0] {S_IDLE, S_CMD, S_RD, S_WT} st_t;

  st_t           st;
  logic [2:0]    step;
  logic [1:0]    op_q;
  logic          mode_q;
  logic [AW-1:0] addr_q;
  logic [7:0]    data_q;
  logic [CW-1:0] cnt;
  logic [1:0]    good;
  logic          prev6, havep;

  wire is_prog  = (op_q == 2'd0);
  wire is_sect  = (op_q == 2'd1);
  wire last_cmd = is_prog ? (step == 3'd3) : (step == 3'd5);
  wire exp7     = is_prog ? data_q[7] : 1'b1;

  logic [CW-1:0] lim;
  always_comb begin
    if (is_prog)      lim = CW'(PROG_TMO);
    else if (is_sect) lim = CW'(SECT_TMO);
    else              lim = CW'(CHIP_TMO);
  end

  wire qual    = mode_q ? (bus_rdata[7] == exp7) : (havep && (bus_rdata[6] == prev6));
  wire hit     = (st == S_WT) && qual && (good == 2'd2);
  wire expired = (cnt == lim - CW'(1));

  assign busy   = (st != S_IDLE);
  assign bus_wr = (st == S_CMD);
  assign bus_rd = (st == S_RD);

  always_comb begin
    bus_addr  = '0;
    bus_wdata = 8'h00;
    if (st == S_CMD) begin
      case (step)
        3'd0: begin bus_addr = KEY_A; bus_wdata = 8'hAA; end
        3'd1: begin bus_addr = KEY_B; bus_wdata = 8'h55; end
        3'd2: begin bus_addr = KEY_A; bus_wdata = is_prog ? 8'hA0 : 8'h80; end
        3'd3: begin
          bus_addr  = is_prog ? addr_q : KEY_A;
          bus_wdata = is_prog ? data_q : 8'hAA;
        end
        3'd4: begin bus_addr = KEY_B; bus_wdata = 8'h55; end
        default: begin
          bus_addr  = is_sect ? addr_q : KEY_A;
          bus_wdata = is_sect ? 8'h30 : 8'h10;
        end
      endcase
    end else if (st == S_RD || st == S_WT) begin
      bus_addr = addr_q;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= S_IDLE;
      step   <= '0;
      op_q   <= '0;
      mode_q <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      cnt    <= '0;
      good   <= '0;
      prev6  <= 1'b0;
      havep  <= 1'b0;
      done   <= 1'b0;
      err    <= 1'b0;
    end else begin
      done <= 1'b0;
      err  <= 1'b0;
      case (st)
        S_IDLE: if (start) begin
          op_q   <= op;
          mode_q <= poll_mode;
          addr_q <= start_addr;
          data_q <= start_data;
          step   <= '0;
          st     <= S_CMD;
        end
        S_CMD: begin
          if (last_cmd) begin
            st    <= S_RD;
            cnt   <= '0;
            good  <= '0;
            havep <= 1'b0;
          end else begin
            step <= step + 3'd1;
          end
        end
        S_RD: begin
          cnt <= cnt + CW'(1);
          if (expired) begin
            done <= 1'b1;
            err  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_WT;
          end
        end
        default: begin
          cnt   <= cnt + CW'(1);
          prev6 <= bus_rdata[6];
          havep <= 1'b1;
          good  <= qual ? good + 2'd1 : 2'd0;
          if (hit) begin
            done <= 1'b1;
            st   <= S_IDLE;
          end else if (expired) begin
            done <= 1'b1;
            err  <= 1'b1;
            st   <= S_IDLE;
          end else begin
            st <= S_RD;
          end
        end
      endcase
    end
  end

  // R1
  start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> (bus_wr && bus_addr == KEY_A && bus_wdata == 8'hAA));

  // R5
  rd_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (!bus_rd && !bus_wr));

  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R9
  busy_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> done);

  // R10
  err_with_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    err |-> done);

  // R10
  budget_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_RD || st == S_WT) |-> (cnt < lim));

endmodule

// File: tb/tb_flash_poll_engine.sv
`timescale 1ns/1ps
module tb_flash_poll_engine;
  localparam int AW = 19;
  localparam int PT = 300;
  localparam int ST = 500;
  localparam int CT = 700;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [1:0] op = 2'd0;
  logic poll_mode = 1'b0;
  logic [AW-1:0] start_addr = '0;
  logic [7:0] start_data = 8'h00;
  logic busy, done, err, bus_wr, bus_rd;
  logic [AW-1:0] bus_addr;
  logic [7:0] bus_wdata;
  logic [7:0] bus_rdata;

  always #2 clk = ~clk;

  flash_poll_engine #(.AW(AW), .PROG_TMO(PT), .SECT_TMO(ST), .CHIP_TMO(CT)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .poll_mode(poll_mode),
    .start_addr(start_addr), .start_data(start_data), .busy(busy), .done(done),
    .err(err), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata));

  int checks = 0;
  int failures = 0;
  int cyc = 0;

  // device model
  logic          mclr = 1'b0;
  int            cfg_busy = 0, cfg_ftog = -1, cfg_fdat = -1;
  logic          cfg_erase = 1'b0;
  logic [7:0]    cfg_true = 8'h00;
  logic [AW-1:0] cfg_addr = '0;
  int            wcnt, rcnt, wlast_cyc, first_rd_cyc, dcnt;
  logic          tog, bad_addr;
  logic [AW-1:0] wa [16];
  logic [7:0]    wd [16];
  logic [7:0]    rlog [256];
  logic [7:0]    v;

  always @(posedge clk) cyc <= cyc + 1;

  always @(posedge clk) begin
    if (mclr) begin
      wcnt <= 0; rcnt <= 0; tog <= 1'b0; bad_addr <= 1'b0; dcnt <= 0;
      wlast_cyc <= 0; first_rd_cyc <= 0; bus_rdata <= 8'h00;
    end else begin
      if (done) dcnt <= dcnt + 1;
      if (bus_wr) begin
        if (wcnt < 16) begin wa[wcnt] <= bus_addr; wd[wcnt] <= bus_wdata; end
        wcnt <= wcnt + 1;
        wlast_cyc <= cyc;
      end
      if (bus_rd) begin
        if (bus_addr != cfg_addr) bad_addr <= 1'b1;
        if (rcnt == 0) first_rd_cyc <= cyc;
        if (rcnt < cfg_busy) begin
          v = {cfg_erase ? 1'b0 : ~cfg_true[7], tog, 6'b0};
          if (rcnt == cfg_fdat) v[7] = cfg_erase ? 1'b1 : cfg_true[7];
          if (rcnt != cfg_ftog - 1) tog <= ~tog;
        end else begin
          v = cfg_true;
        end
        bus_rdata <= v;
        if (rcnt < 256) rlog[rcnt] <= v;
        rcnt <= rcnt + 1;
      end
    end
  end

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic int exp_reads(input logic m, input logic e7, input int n);
    int run = 0;
    for (int i = 0; i < n && i < 256; i++) begin
      bit q;
      q = m ? (rlog[i][7] == e7) : (i > 0 && rlog[i][6] == rlog[i-1][6]);
      run = q ? run + 1 : 0;
      if (run == 3) return i + 1;
    end
    return -1;
  endfunction

  task automatic run_op(input string nm, input logic [1:0] o, input logic m,
                        input logic [AW-1:0] a, input logic [7:0] d, input int bn,
                        input int ft, input int fd, input bit exp_to, input bit poke);
    logic [AW-1:0] ea [6];
    logic [7:0]    ed [6];
    int ec, n, lim, wsnap;
    cfg_busy = bn; cfg_ftog = ft; cfg_fdat = fd;
    cfg_erase = (o != 2'd0); cfg_true = (o == 2'd0) ? d : 8'hFF; cfg_addr = a;
    @(negedge clk) mclr = 1'b1;
    @(negedge clk) mclr = 1'b0;
    op = o; poll_mode = m; start_addr = a; start_data = d; start = 1'b1;
    @(negedge clk) start = 1'b0;
    chk(busy == 1'b1, {"R1 busy after start ", nm}, busy, 1);
    n = 0;
    while (!done && n < 4000) begin
      if (poke && n == 3) begin op = 2'd2; start = 1'b1; end
      @(negedge clk);
      start = 1'b0;
      n++;
    end
    chk(done == 1'b1, {"R9 done seen ", nm}, done, 1);
    chk(err == exp_to, {exp_to ? "R10 err " : "R9 err low ", nm}, err, exp_to);
    ea[0] = 19'h5555; ed[0] = 8'hAA; ea[1] = 19'h2AAA; ed[1] = 8'h55;
    if (o == 2'd0) begin
      ec = 4; ea[2] = 19'h5555; ed[2] = 8'hA0; ea[3] = a; ed[3] = d;
    end else begin
      ec = 6; ea[2] = 19'h5555; ed[2] = 8'h80; ea[3] = 19'h5555; ed[3] = 8'hAA;
      ea[4] = 19'h2AAA; ed[4] = 8'h55;
      ea[5] = (o == 2'd1) ? a : 19'h5555; ed[5] = (o == 2'd1) ? 8'h30 : 8'h10;
    end
    chk(wcnt == ec, {"R2/R3/R4 write count ", nm}, wcnt, ec);
    for (int i = 0; i < ec && i < wcnt; i++) begin
      chk(wa[i] == ea[i], {(o == 0) ? "R2" : (o == 1) ? "R3" : "R4", " addr ", nm}, wa[i], ea[i]);
      chk(wd[i] == ed[i], {(o == 0) ? "R2" : (o == 1) ? "R3" : "R4", " data ", nm}, wd[i], ed[i]);
    end
    chk(rcnt > 0 && first_rd_cyc > wlast_cyc, {"R5 read after final write ", nm}, first_rd_cyc, wlast_cyc + 1);
    chk(bad_addr == 1'b0, {"R5 read address ", nm}, bad_addr, 0);
    if (exp_to) begin
      lim = (o == 2'd0) ? PT : (o == 2'd1) ? ST : CT;
      chk(cyc - wlast_cyc == lim + 1, {"R10 timeout edge ", nm}, cyc - wlast_cyc, lim + 1);
    end else begin
      int er;
      er = exp_reads(m, (o == 2'd0) ? d[7] : 1'b1, rcnt);
      chk(rcnt == er, {m ? "R7/R8 read count " : "R6/R8 read count ", nm}, rcnt, er);
    end
    @(negedge clk);
    chk(done == 1'b0 && busy == 1'b0, {"R9 single pulse, idle ", nm}, {done, busy}, 0);
    if (poke) begin
      wsnap = wcnt;
      repeat (12) @(negedge clk);
      chk(wcnt == wsnap && dcnt == 1, {"R1 start ignored while busy ", nm}, dcnt, 1);
    end
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({busy, done, err, bus_wr, bus_rd} == 5'b0, "R1 reset outputs", {busy, done, err, bus_wr, bus_rd}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(busy == 1'b0 && bus_rd == 1'b0, "R1 idle after reset", {busy, bus_rd}, 0);
  endtask

  task automatic t_prog_toggle();   run_op("prog toggle",   2'd0, 1'b0, 19'h1_2345, 8'h5A, 5, -1, -1, 1'b0, 1'b0); endtask
  task automatic t_prog_data();     run_op("prog data",     2'd0, 1'b1, 19'h0_0F00, 8'h3C, 6, -1, -1, 1'b0, 1'b0); endtask
  task automatic t_sect_glitch();   run_op("sector glitch", 2'd1, 1'b0, 19'h3_4000, 8'h00, 9, 3, -1, 1'b0, 1'b0); endtask
  task automatic t_chip_glitch();   run_op("chip glitch",   2'd2, 1'b1, 19'h0_0000, 8'h00, 8, -1, 2, 1'b0, 1'b0); endtask
  task automatic t_prog_dglitch();  run_op("prog dglitch",  2'd0, 1'b1, 19'h7_FFFF, 8'hC3, 7, -1, 4, 1'b0, 1'b0); endtask
  task automatic t_ignore_start();  run_op("ignore start",  2'd0, 1'b0, 19'h0_1111, 8'h81, 4, -1, -1, 1'b0, 1'b1); endtask
  task automatic t_prog_timeout();  run_op("prog timeout",  2'd0, 1'b1, 19'h0_2222, 8'h11, 100000, -1, -1, 1'b1, 1'b0); endtask
  task automatic t_sect_timeout();  run_op("sect timeout",  2'd1, 1'b0, 19'h5_0000, 8'h00, 100000, -1, -1, 1'b1, 1'b0); endtask
  task automatic t_chip_timeout();  run_op("chip timeout",  2'd3, 1'b1, 19'h0_0000, 8'h00, 100000, -1, -1, 1'b1, 1'b0); endtask

  initial begin
    t_reset();
    t_prog_toggle();
    t_prog_data();
    t_sect_glitch();
    t_chip_glitch();
    t_prog_dglitch();
    t_ignore_start();
    t_prog_timeout();
    t_sect_timeout();
    t_chip_timeout();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=%0d expected=0", cyc);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule